// File: doc/BRIEF.md
# Prescaled SPI Byte Controller

This block is a byte-wide SPI controller. It sits behind a small register interface with three words: control, status and data. Software sets the enable bit and a 7-bit clock divider in the control word. It then writes a byte to the data word, and the block shifts that byte out on MOSI while it shifts a byte in from MISO. The serial clock comes from the block's own clock. Each half of an SCK period lasts (divider + 1) input cycles, so SCK runs at fin / (2 * (divider + 1)).

Chip select is driven outside the block. The block makes one bus cycle: SCK idles low, MOSI carries the MSB first and changes only while SCK falls, and MISO is captured while SCK rises. When a frame ends, the received byte is stored in a single holding buffer and the receive-full flag sets. Reading the data word returns that byte and clears the flag.

Sequencing is done by a three-state machine.
- In IDLE, SCK and MOSI are low.
- LOW is the SCK-low half of a bit.
- HIGH is the SCK-high half of a bit.

The machine moves between states as follows.
- IDLE→LOW happens on an accepted data write (launch).
- LOW→HIGH happens on a prescaler tick, and MISO is sampled.
- HIGH→LOW happens on a tick when more bits remain, and the next bit is shifted out.
- HIGH→IDLE happens on a tick after the last bit (frame done).
- Any state→IDLE happens when the enable bit is cleared (abort).

Top module: `spi_byte_ctrl`

## Requirements
- R1: After reset, the control word reads 0: enable, frame-size bit (bit 1), clock-mode bit (bit 2), receive and transmit interrupt enables (bits 3, 4) and divider (bits 14:8) are all zero. The status word also reads 0, and SCK and MOSI are low.
- R2: A control write takes an 8-bit divider request from bits 15:8. A request above 0x7F is stored as 0x7F, and smaller requests are stored unchanged. The stored value reads back in bits 14:8.
- R3: Each SCK half period lasts divider+1 clock cycles. A frame keeps busy high for 16*(divider+1) cycles, and SCK is high for half of them.
- R4: Writing the data word (address 2) while enabled and idle starts a frame. Status bit 0 (busy) is set from the next cycle until the frame ends.
- R5: Mode 0 timing, MSB first. MOSI never changes while SCK rises, and the byte received is the MISO bits captured on the eight rising SCK edges, first bit as MSB.
- R6: Status bit 1 (receive-full) sets when a frame ends. A read of the data word returns the byte in bits 7:0 and clears the flag, so a second read finds it clear.
- R7: A data write while busy is ignored. The running frame finishes unchanged, and no second frame follows.
- R8: A data write while the enable bit (control bit 0) is clear starts nothing.
- R9: While no frame is running, MOSI and SCK are driven low, even when the last bit sent was 1.
- R10: Clearing the enable bit ends a running frame by the next cycle. SCK, MOSI and busy return low, and no byte is deposited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data read clears receive-full) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | BUS_W (16) | Write data |
| bus_rdata | output | BUS_W (16) | Read data for the selected register |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out, idles low |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: a 7-bit divider, 8-bit frames and a 16-bit register bus. It runs frames with divider values 0, 1 and 3 to keep them short. It also runs one frame with the saturated value 0x7F, which is a 2048-cycle frame, so both the smallest and largest half periods are timed. A serial peripheral model presents chosen MISO bytes. A scoreboard compares every byte seen on MOSI with the byte queued by the driver. This reaches the MSB-first ordering, the ignored writes during a frame and while disabled, and an abort in the middle of a bit.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } frame_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int CB_EN      = 0;
    localparam int CB_WIDE    = 1;
    localparam int CB_ALTCLK  = 2;
    localparam int CB_RXIE    = 3;
    localparam int CB_TXIE    = 4;
    localparam int CB_DIV_LSB = 8;

    localparam int SB_BUSY    = 0;
    localparam int SB_RXFULL  = 1;

endpackage

// File: rtl/spi_prescaler.sv
module spi_prescaler #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= div;
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q <= div;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tick = run && !restart && (cnt_q == '0);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               sample,
    input  logic               shift,
    input  logic               active,
    input  logic               miso,
    output logic               mosi,
    output logic               last_bit,
    output logic [FRAME_W-1:0] rx_word
);

    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-1:0] rx_sr;
    logic [CNT_W-1:0]   bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            bit_idx <= '0;
        end else if (load) begin
            tx_sr   <= load_data;
            bit_idx <= '0;
        end else if (shift) begin
            tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample) begin
            rx_sr <= {rx_sr[FRAME_W-2:0], miso};
        end
    end

    assign mosi     = active ? tx_sr[FRAME_W-1] : 1'b0;
    assign last_bit = (bit_idx == LAST_IDX);
    assign rx_word  = rx_sr;

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_byte_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic stop,
    input  logic launch,
    input  logic tick,
    input  logic last_bit,
    output logic busy,
    output logic sck,
    output logic sample,
    output logic shift,
    output logic done
);

    frame_state_e state_q;
    frame_state_e state_d;
    logic         halt;

    assign halt = stop || !enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)   state_d = ST_LOW;
            ST_LOW:  if (tick)     state_d = ST_HIGH;
            ST_HIGH: if (tick)     state_d = last_bit ? ST_IDLE : ST_LOW;
            default:               state_d = ST_IDLE;
        endcase
        if (halt) begin
            state_d = ST_IDLE;
        end
    end

    always_comb begin
        busy   = 1'b0;
        sck    = 1'b0;
        sample = 1'b0;
        shift  = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOW: begin
                busy   = 1'b1;
                sample = tick && !halt;
            end
            ST_HIGH: begin
                busy  = 1'b1;
                sck   = 1'b1;
                shift = tick && !halt && !last_bit;
                done  = tick && !halt && last_bit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_byte_pkg::*;
#(
    parameter int BUS_W   = 16,
    parameter int DIV_W   = 7,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic               busy,
    input  logic               frame_done,
    input  logic [FRAME_W-1:0] rx_word,
    output logic               enable,
    output logic               stop,
    output logic               launch,
    output logic [DIV_W-1:0]   div_q,
    output logic               rx_full,
    output logic [BUS_W-1:0]   bus_rdata
);

    localparam logic [DIV_W:0] DIV_MAX = {1'b0, {DIV_W{1'b1}}};

    logic               wr_ctrl;
    logic               wr_data;
    logic               rd_data;
    logic               wide_q;
    logic               altclk_q;
    logic               rxie_q;
    logic               txie_q;
    logic [DIV_W:0]     div_req;
    logic [FRAME_W-1:0] rx_buf;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign rd_data = bus_rd && (bus_addr == A_DATA);
    assign div_req = bus_wdata[CB_DIV_LSB +: DIV_W+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            wide_q   <= 1'b0;
            altclk_q <= 1'b0;
            rxie_q   <= 1'b0;
            txie_q   <= 1'b0;
            div_q    <= '0;
        end else if (wr_ctrl) begin
            enable   <= bus_wdata[CB_EN];
            wide_q   <= bus_wdata[CB_WIDE];
            altclk_q <= bus_wdata[CB_ALTCLK];
            rxie_q   <= bus_wdata[CB_RXIE];
            txie_q   <= bus_wdata[CB_TXIE];
            div_q    <= (div_req > DIV_MAX) ? DIV_MAX[DIV_W-1:0] : div_req[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (frame_done) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
        end else if (rd_data) begin
            rx_full <= 1'b0;
        end
    end

    assign stop   = wr_ctrl && !bus_wdata[CB_EN];
    assign launch = wr_data && enable && !busy;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CB_EN]                 = enable;
                bus_rdata[CB_WIDE]               = wide_q;
                bus_rdata[CB_ALTCLK]             = altclk_q;
                bus_rdata[CB_RXIE]               = rxie_q;
                bus_rdata[CB_TXIE]               = txie_q;
                bus_rdata[CB_DIV_LSB +: DIV_W]   = div_q;
            end
            A_STAT: begin
                bus_rdata[SB_BUSY]   = busy;
                bus_rdata[SB_RXFULL] = rx_full;
            end
            A_DATA: bus_rdata[FRAME_W-1:0] = rx_buf;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
    import spi_byte_pkg::*;
#(
    parameter int BUS_W   = 16,
    parameter int DIV_W   = 7,
    parameter int FRAME_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);

    logic               enable;
    logic               stop;
    logic               launch;
    logic [DIV_W-1:0]   div_q;
    logic               rx_full;
    logic               busy;
    logic               tick;
    logic               sample;
    logic               shift;
    logic               frame_done;
    logic               last_bit;
    logic [FRAME_W-1:0] rx_word;

    spi_ctrl_regs #(.BUS_W(BUS_W), .DIV_W(DIV_W), .FRAME_W(FRAME_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .busy       (busy),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .enable     (enable),
        .stop       (stop),
        .launch     (launch),
        .div_q      (div_q),
        .rx_full    (rx_full),
        .bus_rdata  (bus_rdata)
    );

    spi_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .run     (busy),
        .div     (div_q),
        .tick    (tick)
    );

    spi_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .stop     (stop),
        .launch   (launch),
        .tick     (tick),
        .last_bit (last_bit),
        .busy     (busy),
        .sck      (spi_sck),
        .sample   (sample),
        .shift    (shift),
        .done     (frame_done)
    );

    spi_shift_engine #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .load_data (bus_wdata[FRAME_W-1:0]),
        .sample    (sample),
        .shift     (shift),
        .active    (busy),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .last_bit  (last_bit),
        .rx_word   (rx_word)
    );

endmodule

// File: rtl/spi_byte_ctrl_chk.sv
module spi_byte_ctrl_chk
    import spi_byte_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int DIV_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic             spi_sck,
    input logic             spi_mosi,
    input logic             enable,
    input logic             busy,
    input logic             rx_full,
    input logic [DIV_W-1:0] div_q,
    input logic             frame_done
);

    p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!spi_sck && !spi_mosi));

    p_div_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[CB_DIV_LSB + DIV_W]) |=> (div_q == {DIV_W{1'b1}}));

    p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA && enable && !busy) |=> busy);

    p_disabled_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA && !enable && !busy) |=> !busy);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && !bus_wdata[CB_EN]) |=> (!busy && !spi_sck && !spi_mosi));

    p_rx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DATA && !frame_done) |=> !rx_full);

    p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rx_full);

    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_mosi));

endmodule

bind spi_byte_ctrl spi_byte_ctrl_chk #(.BUS_W(BUS_W), .DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi),
    .enable     (enable),
    .busy       (busy),
    .rx_full    (rx_full),
    .div_q      (div_q),
    .frame_done (frame_done)
);

// File: tb/spi_byte_ctrl_tb_top.sv
module spi_byte_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0] exp_q[$];
    logic [7:0] mon_sr = 8'h0;
    int         mon_cnt = 0;
    logic [7:0] slv_sr = 8'h0;

    spi_byte_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    always #2.5 clk = ~clk;

    assign spi_miso = slv_sr[7];

    always @(negedge spi_sck) slv_sr = {slv_sr[6:0], 1'b0};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: collects MOSI on rising SCK, compares against the scoreboard (R5)
    always @(posedge spi_sck) begin
        mon_sr = {mon_sr[6:0], spi_mosi};
        mon_cnt++;
        if (mon_cnt == 8) begin
            mon_cnt = 0;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected frame", int'(mon_sr), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(mon_sr == e, "R5 mosi byte", int'(mon_sr), int'(e));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL WATCHDOG act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1;
        bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_ctrl(input logic en, input logic [7:0] div_req);
        bus_write(2'd0, {div_req, 7'h0, en});
    endtask

    // driver: queue the expected MOSI byte, start a frame, time it and read back the result
    task automatic run_frame(input logic [7:0] tx, input logic [7:0] rx, input int div);
        int n;
        int hi;
        logic [15:0] d;
        n = 0;
        hi = 0;
        slv_sr = rx;
        exp_q.push_back(tx);
        bus_write(2'd2, {8'h0, tx});
        bus_addr = 2'd1;
        #1;
        while (bus_rdata[0] && n < 5000) begin
            n++;
            if (spi_sck) hi++;
            @(negedge clk);
            #1;
        end
        check(n == 16 * (div + 1), "R3 frame length", n, 16 * (div + 1));
        check(hi == 8 * (div + 1), "R3 sck high cycles", hi, 8 * (div + 1));
        check(!spi_sck && !spi_mosi, "R9 idle lines", {spi_sck, spi_mosi}, 0);
        bus_read(2'd1, d);
        check(d[1] == 1'b1, "R6 rx full set", d, 16'h2);
        bus_read(2'd2, d);
        check(d[7:0] == rx, "R5 received byte", d[7:0], rx);
        bus_read(2'd1, d);
        check(d[1] == 1'b0, "R6 rx full cleared", d, 16'h0);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        logic [15:0] d;
        repeat (4) @(negedge clk);
        #1;
        check(!spi_sck && !spi_mosi, "R1 lines in reset", {spi_sck, spi_mosi}, 0);
        rst_n = 1'b1;
        bus_read(2'd0, d);
        check(d == 16'h0, "R1 control reset", d, 0);
        bus_read(2'd1, d);
        check(d == 16'h0, "R1 status reset", d, 0);

        set_ctrl(1'b1, 8'd0);
        bus_read(2'd0, d);
        check(d == 16'h0001, "R2 divider 0 stored", d, 16'h0001);
        run_frame(8'hA5, 8'h3C, 0);

        set_ctrl(1'b1, 8'd3);
        bus_read(2'd0, d);
        check(d == 16'h0301, "R2 divider 3 stored", d, 16'h0301);
        run_frame(8'h5A, 8'hC3, 3);

        set_ctrl(1'b1, 8'd200);
        bus_read(2'd0, d);
        check(d == 16'h7F01, "R2 divider saturates", d, 16'h7F01);
        run_frame(8'h81, 8'h7E, 127);

        set_ctrl(1'b1, 8'd1);
        run_frame(8'hFF, 8'h00, 1);

        // R4/R7: write while busy is ignored
        slv_sr = 8'h96;
        exp_q.push_back(8'h69);
        bus_write(2'd2, 16'h0069);
        bus_read(2'd1, d);
        check(d[0] == 1'b1, "R4 busy after launch", d, 16'h1);
        repeat (5) @(negedge clk);
        bus_write(2'd2, 16'h0012);
        bus_addr = 2'd1;
        #1;
        while (bus_rdata[0]) begin
            @(negedge clk);
            #1;
        end
        repeat (40) @(negedge clk);
        bus_read(2'd1, d);
        check(d == 16'h0002, "R7 no second frame", d, 16'h0002);
        bus_read(2'd2, d);
        check(d[7:0] == 8'h96, "R7 first frame intact", d[7:0], 8'h96);
        check(exp_q.size() == 0 && mon_cnt == 0, "R7 scoreboard", mon_cnt, 0);

        // R8: disabled write
        set_ctrl(1'b0, 8'd1);
        bus_write(2'd2, 16'h0055);
        begin
            int toggles;
            toggles = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (spi_sck) toggles++;
            end
            check(toggles == 0, "R8 no sck while disabled", toggles, 0);
        end
        bus_read(2'd1, d);
        check(d == 16'h0000, "R8 stays idle", d, 0);
        check(mon_cnt == 0, "R8 no bits", mon_cnt, 0);

        // R10: abort mid-frame
        set_ctrl(1'b1, 8'd3);
        slv_sr = 8'hFF;
        exp_q.push_back(8'hF0);
        bus_write(2'd2, 16'h00F0);
        repeat (20) @(negedge clk);
        bus_write(2'd0, 16'h0300);
        #1;
        check(!spi_sck && !spi_mosi, "R10 lines idle after abort", {spi_sck, spi_mosi}, 0);
        mon_cnt = 0;
        exp_q.delete();
        bus_read(2'd1, d);
        check(d == 16'h0000, "R10 not busy and no byte", d, 0);

        // R10 recovery then normal frame
        set_ctrl(1'b1, 8'd1);
        run_frame(8'h3C, 8'hA5, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule